// File: doc/BRIEF.md
# Address-Masked GPIO Controller with Per-Pin Interrupts

This block is an eight-pin general-purpose I/O controller that sits on a simple memory-mapped register bus with byte-wide data. Each pin can be an input or an output. The data port takes its bit mask from the address, so one bus write can change any chosen subset of the output pins without a read-modify-write. Each pin also has its own interrupt detector. It can be set to level or edge sensing, to either polarity, or to fire on both edges.

Pin inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised value with its previous sample. Edge events are latched until software clears them. Level events follow the pin and are not latched. A raw status, an enable and a masked status are available to software. A single interrupt line is the OR of all masked status bits. Reads return data combinationally in the same cycle as the access. Writes take effect at the clock edge.

Address map, in bytes. Offsets 0x000 to 0x3FC form the data window, and address bits [9:2] are the pin mask. The configuration registers are: 0x400 direction, 0x404 sense, 0x408 both-edges, 0x40C event, 0x410 enable, 0x414 raw status (read-only), 0x418 masked status (read-only) and 0x41C clear (write-only). All other offsets are unmapped.

Top module: `pinbank_gpio`

## Requirements
- R1: A synchronous active-low reset clears every register. After reset, `pin_oe` and `pin_out` are 0, `irq` is 0 and every register reads 0.
- R2: Writing the direction register (0x400) sets `pin_oe` to the written byte from the next cycle on: 1 means output, 0 means input. `pin_oe` changes on no other access.
- R3: A write in the data window (0x000 to 0x3FC) changes only output-register bits whose mask bit is set. Pin n uses address bit n+2. `pin_out` shows the output register.
- R4: A data write to a pin whose direction bit is 0 leaves that pin's output bit unchanged. The bit is still unchanged after the pin is later made an output.
- R5: A data-window read returns, for each pin whose mask bit is set, the output-register bit if the pin is an output, or else the synchronised input. The synchronised input reflects a pin change two clock edges later. Unmasked bits read 0.
- R6: With sense bit 1 (0x404), a pin is level-sensitive. Event bit 1 means active high and 0 means active low. Its raw status follows the synchronised pin, appearing two edges after the pin change, and the clear register does not affect it.
- R7: With sense bit 0 and both-edges bit 0, event bit 1 latches a rising edge and event bit 0 latches a falling edge. The latched raw status appears three edges after the pin change. An edge of the other polarity is ignored.
- R8: With sense bit 0 and both-edges bit 1 (0x408), either edge is latched and the event bit is ignored.
- R9: The masked status (0x418) is the raw status (0x414) ANDed with the enable register (0x410). `irq` is the OR of the masked bits. Writing enable to 0 holds `irq` at 0 from the next cycle.
- R10: Writing the clear register (0x41C) clears the latched edge bits that are written as 1. Bits written as 0 have no effect.
- R11: The configuration registers read back as written. The clear register reads 0. Unmapped offsets (0x420 and up) read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Read data, valid while a read is selected, otherwise 0 |
| pin_in | input | N_PINS | Asynchronous pin inputs |
| pin_out | output | N_PINS | Output register value |
| pin_oe | output | N_PINS | Output enable (direction register) |
| irq | output | 1 | Combined interrupt request |

## Verification
The data port is tried with single-pin masks, partial masks and the full mask. Each of these goes to a mix of input and output pins. This tells a correct mask decode apart from an off-by-one address bit, and it tells dropped input-pin writes apart from accepted ones. The interrupt logic is tried with steps in the pin value under four settings: level high, level low, single rising edge, and both edges. This tells latched sources apart from followed ones, and it tells a rising edge caught only in both-edges mode apart from one caught in every mode. Clears are tried with zero bits, with unrelated bits and with the matching bit. Enable is cleared while raw status is pending. Each clock, a reference model also checks every output against its own cycle-accurate view.

// File: rtl/pinbank_pkg.sv
// Shared types for the address-masked GPIO controller.
// Assumes byte addresses with the configuration index in bits [4:2].
package pinbank_pkg;

    // Configuration register index inside the control page
    typedef enum logic [2:0] {
        REG_DIR    = 3'd0,
        REG_SENSE  = 3'd1,
        REG_BOTH   = 3'd2,
        REG_EVENT  = 3'd3,
        REG_ENABLE = 3'd4,
        REG_RAW    = 3'd5,
        REG_MASKED = 3'd6,
        REG_CLEAR  = 3'd7
    } pb_reg_e;

    // Address space classes
    typedef enum logic [1:0] {
        SPACE_DATA = 2'd0,
        SPACE_CFG  = 2'd1,
        SPACE_NONE = 2'd2
    } pb_space_e;

endpackage

// File: rtl/pinbank_sync.sv
// Two-flop input synchroniser plus one history stage for edge detection.
// Assumes pin_in is asynchronous. sync_q lags pin_in by two edges,
// and prev_q lags sync_q by one edge.
module pinbank_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    // Shift the inputs through the synchroniser and history stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/pinbank_detect.sv
// Per-pin interrupt detection: followed level sources and latched edge sources.
// Assumes sync/prev come from pinbank_sync and clr_bits is a one-cycle pulse.
module pinbank_detect #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_q,
    input  logic [N-1:0] prev_q,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] both,
    input  logic [N-1:0] event_sel,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] raw
);
    for (genvar p = 0; p < N; p++) begin : g_pin
        logic rise, fall, hit, level_on, latch_q;

        // Classify the current sample pair for this pin
        always_comb begin
            rise     = sync_q[p] & ~prev_q[p];
            fall     = ~sync_q[p] & prev_q[p];
            hit      = both[p] ? (rise | fall) : (event_sel[p] ? rise : fall);
            level_on = event_sel[p] ? sync_q[p] : ~sync_q[p];
        end

        // Hold an edge event until software clears it; a new edge wins
        always_ff @(posedge clk) begin
            if (!rst_n)
                latch_q <= 1'b0;
            else if (!sense[p] && hit)
                latch_q <= 1'b1;
            else if (clr_bits[p])
                latch_q <= 1'b0;
        end

        // Select the raw source by sensing mode
        assign raw[p] = sense[p] ? level_on : latch_q;
    end
endmodule

// File: rtl/pinbank_regs.sv
// Register decode, configuration storage, masked data port and read mux.
// Assumes a single-cycle access strobe; read data is combinational.
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  bus_wdata,
    output logic [N-1:0]  bus_rdata,
    input  logic [N-1:0]  sync_q,
    input  logic [N-1:0]  raw,
    output logic [N-1:0]  dir_q,
    output logic [N-1:0]  sense_q,
    output logic [N-1:0]  both_q,
    output logic [N-1:0]  event_q,
    output logic [N-1:0]  enable_q,
    output logic [N-1:0]  out_q,
    output logic [N-1:0]  clr_bits
);
    localparam int WIN_TOP = N + 2;
    localparam int UP_W    = AW - WIN_TOP;

    pb_space_e    space;
    pb_reg_e      idx;
    logic [N-1:0] amask;
    logic         wr_en;

    // Classify the address into data window, control page or hole
    always_comb begin
        amask = bus_addr[WIN_TOP-1:2];
        idx   = pb_reg_e'(bus_addr[4:2]);
        if (bus_addr[AW-1:WIN_TOP] == UP_W'(0))
            space = SPACE_DATA;
        else if (bus_addr[AW-1:WIN_TOP] == UP_W'(1) && bus_addr[WIN_TOP-1:5] == '0)
            space = SPACE_CFG;
        else
            space = SPACE_NONE;
        wr_en = bus_sel && bus_wr;
    end

    // One-cycle clear pulse for latched edge events
    assign clr_bits = (wr_en && space == SPACE_CFG && idx == REG_CLEAR) ? bus_wdata : '0;

    // Masked data write, dropped for pins configured as inputs
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (wr_en && space == SPACE_DATA)
            out_q <= (out_q & ~(amask & dir_q)) | (bus_wdata & amask & dir_q);
    end

    // Configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            sense_q  <= '0;
            both_q   <= '0;
            event_q  <= '0;
            enable_q <= '0;
        end else if (wr_en && space == SPACE_CFG) begin
            case (idx)
                REG_DIR:    dir_q    <= bus_wdata;
                REG_SENSE:  sense_q  <= bus_wdata;
                REG_BOTH:   both_q   <= bus_wdata;
                REG_EVENT:  event_q  <= bus_wdata;
                REG_ENABLE: enable_q <= bus_wdata;
                default:    ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (space == SPACE_DATA) begin
                bus_rdata = amask & ((dir_q & out_q) | (~dir_q & sync_q));
            end else if (space == SPACE_CFG) begin
                case (idx)
                    REG_DIR:    bus_rdata = dir_q;
                    REG_SENSE:  bus_rdata = sense_q;
                    REG_BOTH:   bus_rdata = both_q;
                    REG_EVENT:  bus_rdata = event_q;
                    REG_ENABLE: bus_rdata = enable_q;
                    REG_RAW:    bus_rdata = raw;
                    REG_MASKED: bus_rdata = raw & enable_q;
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pinbank_gpio.sv
// Top: GPIO controller with address-masked data port and per-pin interrupts.
// Assumes ADDR_W > N_PINS + 2 and N_PINS >= 4; synchronous active-low reset.
module pinbank_gpio #(
    parameter int N_PINS = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);
    logic [N_PINS-1:0] sync_q, prev_q, raw, clr_bits;
    logic [N_PINS-1:0] dir_q, sense_q, both_q, event_q, enable_q, out_q;

    pinbank_sync #(.W(N_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .sync_q(sync_q), .prev_q(prev_q)
    );

    pinbank_detect #(.N(N_PINS)) u_detect (
        .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .prev_q(prev_q),
        .sense(sense_q), .both(both_q), .event_sel(event_q),
        .clr_bits(clr_bits), .raw(raw)
    );

    pinbank_regs #(.N(N_PINS), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sync_q(sync_q), .raw(raw),
        .dir_q(dir_q), .sense_q(sense_q), .both_q(both_q), .event_q(event_q),
        .enable_q(enable_q), .out_q(out_q), .clr_bits(clr_bits)
    );

    // Drive pins and combine the masked interrupt sources
    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |(raw & enable_q);
endmodule

// File: rtl/pinbank_chk.sv
// Port-level assertions for pinbank_gpio, attached with bind.
// Assumes the same parameters as the bound instance.
module pinbank_chk #(
    parameter int N_PINS = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_PINS-1:0] bus_wdata,
    input logic [N_PINS-1:0] bus_rdata,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe,
    input logic              irq
);
    localparam int WIN_TOP = N_PINS + 2;
    localparam int UP_W    = ADDR_W - WIN_TOP;

    logic              wr_dir, wr_data, wr_en0, rd_hole;
    logic [N_PINS-1:0] amask;

    // Independent address classification for the checks
    always_comb begin
        amask   = bus_addr[WIN_TOP-1:2];
        wr_dir  = bus_sel && bus_wr && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1 << (WIN_TOP-2));
        wr_en0  = bus_sel && bus_wr && bus_wdata == '0 &&
                  bus_addr[ADDR_W-1:2] == (ADDR_W-2)'((1 << (WIN_TOP-2)) + 4);
        wr_data = bus_sel && bus_wr && bus_addr[ADDR_W-1:WIN_TOP] == UP_W'(0);
        rd_hole = bus_sel && !bus_wr && bus_addr[ADDR_W-1:WIN_TOP] > UP_W'(1);
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && !irq));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == $past(bus_wdata));

    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(pin_oe));

    p_unmasked_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (pin_out & ~$past(amask)) == ($past(pin_out) & ~$past(amask)));

    p_input_write_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (pin_out & ~$past(pin_oe)) == ($past(pin_out) & ~$past(pin_oe)));

    p_enable_zero_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en0 |=> !irq);

    p_hole_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hole |-> bus_rdata == '0);
endmodule

bind pinbank_gpio pinbank_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/sim_pinbank_gpio.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module sim_pinbank_gpio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, pin_in = '0;
    logic [7:0]  bus_rdata, pin_out, pin_oe;
    logic        irq;

    int checks = 0, errors = 0;
    bit started = 0;

    always #4 clk = ~clk;

    pinbank_gpio u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_dir, m_sense, m_both, m_evt, m_en, m_out, m_lat;
    logic [7:0] hist[$];

    function automatic logic [7:0] hv(int i);
        return (hist.size() > i) ? hist[i] : 8'h00;
    endfunction

    function automatic logic [7:0] m_raw();
        logic [7:0] r;
        logic [7:0] s = hv(1);
        for (int p = 0; p < 8; p++)
            r[p] = m_sense[p] ? (m_evt[p] ? s[p] : !s[p]) : m_lat[p];
        return r;
    endfunction

    function automatic logic [7:0] m_read(logic sel, logic wr, logic [11:0] a);
        logic [7:0] v = 8'h00;
        logic [7:0] s = hv(1);
        if (!sel || wr) return 8'h00;
        if (a[11:10] == 2'b00) begin
            for (int p = 0; p < 8; p++)
                if (a[p+2]) v[p] = m_dir[p] ? m_out[p] : s[p];
        end else if (a[11:10] == 2'b01 && a[9:5] == 5'd0) begin
            case (a[4:2])
                3'd0: v = m_dir;
                3'd1: v = m_sense;
                3'd2: v = m_both;
                3'd3: v = m_evt;
                3'd4: v = m_en;
                3'd5: v = m_raw();
                3'd6: v = m_raw() & m_en;
                default: v = 8'h00;
            endcase
        end
        return v;
    endfunction

    always @(posedge clk) begin
        logic [7:0] s2, pv;
        logic rise, fall, hit, is_clr;
        started = 1;
        if (!rst_n) begin
            m_dir = 0; m_sense = 0; m_both = 0; m_evt = 0; m_en = 0; m_out = 0; m_lat = 0;
            hist.delete();
        end else begin
            s2 = hv(1); pv = hv(2);
            is_clr = bus_sel && bus_wr && bus_addr == 12'h41C;
            for (int p = 0; p < 8; p++) begin
                rise = s2[p] && !pv[p];
                fall = !s2[p] && pv[p];
                hit  = m_both[p] ? (rise || fall) : (m_evt[p] ? rise : fall);
                if (!m_sense[p] && hit) m_lat[p] = 1'b1;
                else if (is_clr && bus_wdata[p]) m_lat[p] = 1'b0;
            end
            if (bus_sel && bus_wr) begin
                if (bus_addr[11:10] == 2'b00) begin
                    for (int p = 0; p < 8; p++)
                        if (bus_addr[p+2] && m_dir[p]) m_out[p] = bus_wdata[p];
                end else if (bus_addr[11:10] == 2'b01 && bus_addr[9:5] == 5'd0) begin
                    case (bus_addr[4:2])
                        3'd0: m_dir = bus_wdata;
                        3'd1: m_sense = bus_wdata;
                        3'd2: m_both = bus_wdata;
                        3'd3: m_evt = bus_wdata;
                        3'd4: m_en = bus_wdata;
                        default: ;
                    endcase
                end
            end
            hist.push_front(pin_in);
            if (hist.size() > 3) void'(hist.pop_back());
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("R2", pin_oe, m_dir, "model pin_oe");
            chk("R3", pin_out, m_out, "model pin_out");
            chk("R9", {7'd0, irq}, {7'd0, |(m_raw() & m_en)}, "model irq");
            chk(bus_addr[11:10] == 2'b00 ? "R5" : "R11", bus_rdata,
                m_read(bus_sel, bus_wr, bus_addr), "model rdata");
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(logic [11:0] a, logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [11:0] a, logic [7:0] exp, string req);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 chk(req, bus_rdata, exp, "read");
        step();
        bus_sel = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1; step();
        // R1 reset state
        chk("R1", pin_oe, 8'h00, "oe after reset");
        chk("R1", {7'd0, irq}, 8'h00, "irq after reset");
        rd(12'h414, 8'h00, "R1");
        // R2 direction
        wr(12'h400, 8'h0F);
        chk("R2", pin_oe, 8'h0F, "direction");
        // R3 masked writes
        wr(12'h00C, 8'hFF);
        chk("R3", pin_out, 8'h03, "mask pins 0,1");
        wr(12'h3FC, 8'hA5);
        chk("R3", pin_out, 8'h05, "full mask, inputs dropped");
        wr(12'h010, 8'h00);
        chk("R3", pin_out, 8'h01, "single pin 2");
        // R4 input-pin writes dropped
        wr(12'h400, 8'hFF);
        chk("R4", pin_out, 8'h01, "dropped bits after output switch");
        wr(12'h400, 8'h0F);
        // R5 reads
        pin_in = 8'hC0; step(3);
        rd(12'h3FC, 8'hC1, "R5");
        rd(12'h200, 8'h80, "R5");
        rd(12'h004, 8'h01, "R5");
        rd(12'h008, 8'h00, "R5");
        // R6 level sensing
        wr(12'h404, 8'h10); wr(12'h40C, 8'h10); wr(12'h410, 8'h10);
        pin_in = 8'hD0; step();
        chk("R6", {7'd0, irq}, 8'h00, "level after one edge");
        step();
        chk("R6", {7'd0, irq}, 8'h01, "level high");
        wr(12'h41C, 8'hFF);
        chk("R6", {7'd0, irq}, 8'h01, "clear ignored on level");
        pin_in = 8'hC0; step(2);
        chk("R6", {7'd0, irq}, 8'h00, "level removed");
        wr(12'h40C, 8'h00);
        chk("R6", {7'd0, irq}, 8'h01, "level low polarity");
        wr(12'h410, 8'h00);
        // R7 single-edge sensing
        wr(12'h404, 8'h00); wr(12'h40C, 8'h20); wr(12'h410, 8'h20); wr(12'h41C, 8'hFF);
        chk("R7", {7'd0, irq}, 8'h00, "edge idle");
        pin_in = 8'hE0; step(2);
        chk("R7", {7'd0, irq}, 8'h00, "rise before latch");
        step();
        chk("R7", {7'd0, irq}, 8'h01, "rise latched");
        // R10 clear
        wr(12'h41C, 8'h00);
        chk("R10", {7'd0, irq}, 8'h01, "zero clear");
        wr(12'h41C, 8'hDF);
        chk("R10", {7'd0, irq}, 8'h01, "other-bit clear");
        wr(12'h41C, 8'h20);
        chk("R10", {7'd0, irq}, 8'h00, "matching clear");
        pin_in = 8'hC0; step(3);
        chk("R7", {7'd0, irq}, 8'h00, "falling ignored");
        // R8 both edges
        wr(12'h408, 8'h40); wr(12'h410, 8'h40); wr(12'h41C, 8'hFF);
        pin_in = 8'h80; step(3);
        chk("R8", {7'd0, irq}, 8'h01, "fall in both mode");
        wr(12'h41C, 8'h40);
        chk("R8", {7'd0, irq}, 8'h00, "cleared");
        pin_in = 8'hC0; step(3);
        chk("R8", {7'd0, irq}, 8'h01, "rise with event 0");
        // R9 enable gating
        wr(12'h410, 8'h00);
        chk("R9", {7'd0, irq}, 8'h00, "enable zero");
        rd(12'h414, 8'h40, "R9");
        rd(12'h418, 8'h00, "R9");
        // R11 readback and holes
        wr(12'h800, 8'hFF);
        rd(12'h800, 8'h00, "R11");
        chk("R11", pin_out, 8'h01, "hole write ignored");
        rd(12'h400, 8'h0F, "R11");
        rd(12'h40C, 8'h20, "R11");
        rd(12'h41C, 8'h00, "R11");
        // R1 reset mid-run
        rst_n = 0; step(2); rst_n = 1; step();
        chk("R1", pin_oe, 8'h00, "oe after second reset");
        rd(12'h408, 8'h00, "R1");
        step(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule